// File: doc/BRIEF.md
# Bit-Run Position Finder

This unit searches a 64-bit word for the first group of at least `n` adjacent one bits and reports where that group begins. Positions count from the most significant bit, which is position 0. If the word has no such group, the result is -1.

The search runs over several clocks. In each iteration the unit does two things. It counts the leading zeros of its working word, shifts them out and adds the count to a position accumulator. It then counts the leading ones of what remains by counting the leading zeros of the complement. If the count of ones reaches `n`, the accumulator is the answer. If it does not, those ones are also shifted out and added to the accumulator, and the next iteration starts.

The leading-zero count comes from a built-in function. It smears the word to the right with OR, takes a masked population count and subtracts that count from 64. A caller pulses `start` while the unit is idle, then waits for the one-cycle `done` pulse that carries the result.

Top module: `bitrun_locator`

## Requirements
- R1: While reset is asserted, `busy` and `done` are 0 and `pos_out` is 0.
- R2: A `start` seen while idle captures `word_in` and `run_len`, and `busy` is 1 from the next cycle.
- R3: `start`, `word_in` and `run_len` are ignored while `busy` is 1. Changing them during a search leaves both its result and its length unchanged.
- R4: For `run_len` n ≥ 1, `pos_out` is the MSB-relative index (MSB = 0) of the first bit of the first group of at least n adjacent ones. With n = 4, word 0x0F00000000000000 gives 4 and word 0x0123456789ABCDEF gives 29.
- R5: If no qualifying group exists, including when the word is zero, `pos_out` is 0xFFFFFFFF (-1).
- R6: With n = 0, `pos_out` is the index of the first set bit, or -1 for a zero word.
- R7: Vacated bits are filled with zeros, so a group that reaches the LSB counts only its real ones. All-ones with n = 64 gives 0, and word 0x7 with n = 4 gives -1.
- R8: `done` is high for exactly one cycle, and `busy` is 0 in that cycle and after it.
- R9: One iteration takes one clock. If k shorter groups come before the answer (or, when the answer is -1, the word has k groups in total), `busy` stays high for exactly k+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a search; sampled only while idle |
| word_in | input | 64 | Word to search |
| run_len | input | 7 | Minimum group length n, 0 to 64 |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse, result valid |
| pos_out | output | 32 | Signed start index, or -1 |

## Verification
The hardest paths to reach are the long ones, where many short groups must be stepped over before a hit or a miss. Other hard cases are groups that end exactly at the LSB and the n = 64 boundary.

Directed vectors set up each of these shapes: alternating and nibble-staircase words, a right-aligned group of ones, and an all-ones word. Every single-bit word is applied at two lengths. Random words built by OR-ing several random values produce long groups, so the search mixes hits and misses. A bit-by-bit reference scan predicts both the result and the iteration count.

// File: rtl/bitrun_locator.sv
module bitrun_locator (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] word_in,
  input  logic [6:0]  run_len,
  output logic        busy,
  output logic        done,
  output logic [31:0] pos_out
);

  function automatic logic [6:0] lead_zeros(input logic [63:0] v);
    logic [63:0] x;
    x = v;
    x = x | (x >> 1);
    x = x | (x >> 2);
    x = x | (x >> 4);
    x = x | (x >> 8);
    x = x | (x >> 16);
    x = x | (x >> 32);
    x = x - ((x >> 1) & 64'h5555_5555_5555_5555);
    x = ((x >> 2) & 64'h3333_3333_3333_3333) + (x & 64'h3333_3333_3333_3333);
    x = ((x >> 4) + x) & 64'h0F0F_0F0F_0F0F_0F0F;
    x = x + (x >> 8);
    x = x + (x >> 16);
    x = x + (x >> 32);
    return 7'd64 - x[6:0];
  endfunction

  logic [63:0] wrk;
  logic [6:0]  need;
  logic [6:0]  acc;

  logic [6:0]  zcnt, ocnt, acc_z;
  logic [63:0] wrk_z, wrk_o;
  logic        hit, empty;

  assign zcnt  = lead_zeros(wrk);
  assign wrk_z = wrk << zcnt;
  assign acc_z = acc + zcnt;
  assign ocnt  = lead_zeros(~wrk_z);
  assign wrk_o = wrk_z << ocnt;
  assign hit   = ocnt >= need;
  assign empty = (wrk == 64'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      pos_out <= 32'd0;
      wrk     <= 64'd0;
      need    <= 7'd0;
      acc     <= 7'd0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          wrk  <= word_in;
          need <= run_len;
          acc  <= 7'd0;
        end
      end else if (empty) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        pos_out <= 32'hFFFF_FFFF;
      end else if (hit) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        pos_out <= {25'd0, acc_z};
      end else begin
        wrk <= wrk_o;
        acc <= acc_z + ocnt;
      end
    end
  end

  p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_to_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_search_ends_in_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy ^ done));
  p_result_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pos_out == 32'hFFFF_FFFF || pos_out < 32'd64));
  p_word_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !empty) |=> (done || $countones(wrk) < $past($countones(wrk))));
  p_acc_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> acc <= 7'd64);

endmodule

// File: tb/bitrun_locator_tb.sv
`timescale 1ns/1ps
module bitrun_locator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] word_in = 64'd0;
  logic [6:0]  run_len = 7'd0;
  logic        busy, done;
  logic [31:0] pos_out;

  int n_chk = 0;
  int n_bad = 0;

  bitrun_locator u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
    .run_len(run_len), .busy(busy), .done(done), .pos_out(pos_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ref_scan(input logic [63:0] w, input int n, output int pos, output int runs);
    int run = 0;
    int st = 0;
    bit in_run = 0;
    pos = -1;
    runs = 0;
    for (int i = 0; i < 64; i++) begin
      if (w[63-i]) begin
        if (!in_run) begin in_run = 1; st = i; run = 0; end
        run++;
        if (run >= n) begin pos = st; return; end
      end else if (in_run) begin
        in_run = 0;
        runs++;
      end
    end
    if (in_run) runs++;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (done !== 1'b1 && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_one(input logic [63:0] w, input int n, input string tag);
    int epos, eruns, cyc;
    ref_scan(w, n, epos, eruns);
    @(negedge clk);
    start = 1'b1; word_in = w; run_len = n[6:0];
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {tag, " R2 busy after start"}, busy, 1);
    wait_done(cyc);
    chk(pos_out === epos[31:0], {tag, " result"}, pos_out, epos[31:0]);
    chk(cyc == eruns + 1, {tag, " R9 busy cycles"}, cyc, eruns + 1);
    chk(busy === 1'b0, {tag, " R8 busy low at done"}, busy, 0);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic t_reset;
    #1;
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    chk(done === 1'b0, "R1 done in reset", done, 0);
    chk(pos_out === 32'd0, "R1 result in reset", pos_out, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_stated;
    run_one(64'h0F00_0000_0000_0000, 4, "R4 nibble vector");
    run_one(64'h0, 4, "R5 zero word");
    run_one(64'h0123_4567_89AB_CDEF, 4, "R4 staircase vector");
    run_one(64'hAAAA_AAAA_AAAA_AAAA, 2, "R5 alternating miss");
  endtask

  task automatic t_edges;
    run_one(64'hFFFF_FFFF_FFFF_FFFF, 64, "R7 all ones n64");
    run_one(64'h7FFF_FFFF_FFFF_FFFF, 64, "R7 63 ones n64");
    run_one(64'h7, 3, "R7 lsb group fits");
    run_one(64'h7, 4, "R7 lsb group short");
    run_one(64'hFFFF_FFFF_FFFF_FFFF, 0, "R6 all ones n0");
    run_one(64'h0000_1000_0000_0000, 0, "R6 single bit n0");
    run_one(64'h0, 0, "R6 zero word n0");
  endtask

  task automatic t_single_bits;
    for (int p = 0; p < 64; p++) begin
      run_one(64'd1 << (63 - p), 1, "R4 single bit n1");
      run_one(64'd1 << (63 - p), 2, "R7 single bit n2");
    end
  endtask

  task automatic t_ignore_busy;
    int epos, eruns, cyc;
    logic [63:0] w;
    w = 64'h0123_4567_89AB_CDEF;
    ref_scan(w, 4, epos, eruns);
    @(negedge clk);
    start = 1'b1; word_in = w; run_len = 7'd4;
    @(negedge clk);
    word_in = 64'hFFFF_FFFF_FFFF_FFFF; run_len = 7'd0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 3;
    while (done !== 1'b1 && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(pos_out === epos[31:0], "R3 result unchanged", pos_out, epos[31:0]);
    chk(cyc - 1 == eruns + 1, "R3 length unchanged", cyc - 1, eruns + 1);
    @(negedge clk);
    chk(busy === 1'b0, "R3 no restart", busy, 0);
  endtask

  task automatic t_random;
    for (int k = 0; k < 150; k++) begin
      logic [63:0] w;
      int n;
      w = {$urandom, $urandom};
      if (k % 3 == 1) w = w | {$urandom, $urandom} | {$urandom, $urandom};
      if (k % 3 == 2) w = w | {$urandom, $urandom} | {$urandom, $urandom} | {$urandom, $urandom};
      n = $urandom_range(0, 64);
      if (k % 2 == 0) n = $urandom_range(0, 10);
      run_one(w, n, "R4 random");
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_stated();
    t_edges();
    t_single_bits();
    t_ignore_busy();
    t_random();
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule